// File: doc/BRIEF.md
# ADC Sample Trim and Output Coding Stage

This stage sits between a converter core and its serial output path. For every sample it receives in offset binary, it adds a signed trim of a few LSBs. It clamps the corrected value to the legal code range, can invert every bit, and can re-code the result as twos complement by flipping the most significant bit. All of this work happens in one registered stage.

A sample enters on a cycle where the sample strobe is high. The corrected word appears one clock later with its valid flag. The trim, invert and format controls are read only on strobe cycles. Between strobes the output word is frozen, so a control change can never produce a word built partly under the old settings and partly under the new ones.

Top module: `adcfmt_stage`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fmt_vld` is 0 and `fmt_code` is all zeros.
- R2: `fmt_vld` is high exactly one clock after each cycle on which `smp_stb` is high, and low otherwise.
- R3: `trim_ofs` is a twos-complement value (0x7F = +127, 0x80 = -128). With no clamp, no inversion and `twos_en` = 0, the output equals `smp_code + trim_ofs`.
- R4: When `smp_code + trim_ofs` exceeds 0x3FFF, the corrected value is clamped to 0x3FFF rather than wrapping.
- R5: When `smp_code + trim_ofs` is below zero, the corrected value is clamped to 0x0000 rather than wrapping.
- R6: With `inv_en` = 1, every bit of the clamped value is complemented, so the value v becomes 0x3FFF - v.
- R7: With `twos_en` = 1, bit 13 of the word is flipped after inversion, so offset-binary 0x2000 maps to 0x0000 and 0x0000 maps to 0x2000. With `twos_en` = 0 the word stays in offset binary.
- R8: On cycles where `smp_stb` is low, `fmt_code` keeps its value, and changes to `smp_code`, `trim_ofs`, `inv_en` or `twos_en` have no effect on it.
- R9: With both `inv_en` and `twos_en` set, the order is clamp, then invert, then MSB flip. For example, code 0 with trim 0 gives 0x1FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | Sample present on this cycle |
| smp_code | input | 14 | Raw sample, offset binary |
| trim_ofs | input | 8 | Signed LSB trim, twos complement |
| inv_en | input | 1 | Complement all output bits |
| twos_en | input | 1 | 1 = twos-complement output, 0 = offset binary |
| fmt_code | output | 14 | Corrected and coded sample |
| fmt_vld | output | 1 | Output word is new this cycle |

## Verification
The bench builds the stage with its default widths: a 14-bit sample and an 8-bit trim. With these widths the clamps can only be reached from codes within 128 of either rail. For that reason the random sample generator aims a share of its codes at both rails and draws the trim over its full signed range. Directed cases pin the extreme trims, the MSB-flip points and the combined invert and format path. Strobe-free cycles with changing controls show that the held word does not move.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
  typedef struct packed {
    logic inv;
    logic twos;
  } code_cfg_t;
endpackage

// File: rtl/adcfmt_trim.sv
module adcfmt_trim #(
  parameter int DATA_W = 14,
  parameter int OFS_W  = 8
) (
  input  logic [DATA_W-1:0] code_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [DATA_W-1:0] code_o,
  output logic              hit_hi_o,
  output logic              hit_lo_o
);
  localparam int SUM_W = DATA_W + 2;

  function automatic logic [SUM_W-1:0] trim_sum(input logic [DATA_W-1:0] c,
                                                input logic [OFS_W-1:0] o);
    logic [SUM_W-1:0] ext;
    ext = {{(SUM_W-OFS_W){o[OFS_W-1]}}, o};
    return {2'b00, c} + ext;
  endfunction

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum      = trim_sum(code_i, ofs_i);
    hit_lo_o = sum[SUM_W-1];
    hit_hi_o = !sum[SUM_W-1] && sum[DATA_W];
    if (hit_lo_o)      code_o = '0;
    else if (hit_hi_o) code_o = '1;
    else               code_o = sum[DATA_W-1:0];
  end
endmodule

// File: rtl/adcfmt_code.sv
module adcfmt_code
  import adcfmt_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic [DATA_W-1:0] code_i,
  input  code_cfg_t         cfg_i,
  output logic [DATA_W-1:0] code_o
);
  function automatic logic [DATA_W-1:0] recode(input logic [DATA_W-1:0] c,
                                               input code_cfg_t k);
    logic [DATA_W-1:0] t;
    t = k.inv ? ~c : c;
    t[DATA_W-1] = t[DATA_W-1] ^ k.twos;
    return t;
  endfunction

  assign code_o = recode(code_i, cfg_i);
endmodule

// File: rtl/adcfmt_stage.sv
module adcfmt_stage
  import adcfmt_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [DATA_W-1:0] smp_code,
  input  logic [OFS_W-1:0]  trim_ofs,
  input  logic              inv_en,
  input  logic              twos_en,
  output logic [DATA_W-1:0] fmt_code,
  output logic              fmt_vld
);
  logic [DATA_W-1:0] clamped;
  logic [DATA_W-1:0] coded;
  logic              sat_hi;
  logic              sat_lo;
  code_cfg_t         cfg;

  assign cfg = '{inv: inv_en, twos: twos_en};

  adcfmt_trim #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_trim (
    .code_i   (smp_code),
    .ofs_i    (trim_ofs),
    .code_o   (clamped),
    .hit_hi_o (sat_hi),
    .hit_lo_o (sat_lo)
  );

  adcfmt_code #(.DATA_W(DATA_W)) u_code (
    .code_i (clamped),
    .cfg_i  (cfg),
    .code_o (coded)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_code <= '0;
      fmt_vld  <= 1'b0;
    end else begin
      fmt_vld <= smp_stb;
      if (smp_stb) fmt_code <= coded;
    end
  end
endmodule

// File: rtl/adcfmt_stage_chk.sv
module adcfmt_stage_chk #(
  parameter int DATA_W = 14,
  parameter int OFS_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_stb,
  input logic [DATA_W-1:0] smp_code,
  input logic [OFS_W-1:0]  trim_ofs,
  input logic              inv_en,
  input logic              twos_en,
  input logic [DATA_W-1:0] fmt_code,
  input logic              fmt_vld,
  input logic              sat_hi,
  input logic              sat_lo
);
  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> fmt_vld);
  // R2
  vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !fmt_vld);
  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> $stable(fmt_code));
  // R3
  zero_trim_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && trim_ofs == '0 && !inv_en && !twos_en) |=> fmt_code == $past(smp_code));
  // R4
  clamp_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && sat_hi && !inv_en && !twos_en) |=> fmt_code == {DATA_W{1'b1}});
  // R5
  clamp_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && sat_lo && !inv_en && !twos_en) |=> fmt_code == '0);
  // R7
  msb_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && trim_ofs == '0 && !inv_en && twos_en) |=>
      fmt_code == {~$past(smp_code[DATA_W-1]), $past(smp_code[DATA_W-2:0])});
  // R4 R5
  one_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sat_hi && sat_lo));
endmodule

bind adcfmt_stage adcfmt_stage_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .smp_stb  (smp_stb),
  .smp_code (smp_code),
  .trim_ofs (trim_ofs),
  .inv_en   (inv_en),
  .twos_en  (twos_en),
  .fmt_code (fmt_code),
  .fmt_vld  (fmt_vld),
  .sat_hi   (sat_hi),
  .sat_lo   (sat_lo)
);

// File: tb/adcfmt_stage_test.sv
module adcfmt_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_stb = 1'b0;
  logic [13:0] smp_code = '0;
  logic [7:0]  trim_ofs = '0;
  logic        inv_en = 1'b0;
  logic        twos_en = 1'b0;
  logic [13:0] fmt_code;
  logic        fmt_vld;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int exp_word = 0;

  always #2.5 clk = ~clk;

  adcfmt_stage uut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_code(smp_code),
    .trim_ofs(trim_ofs), .inv_en(inv_en), .twos_en(twos_en),
    .fmt_code(fmt_code), .fmt_vld(fmt_vld)
  );

  function automatic int model(int code, int ofs8, bit inv, bit twos);
    int v;
    int s;
    s = (ofs8 >= 128) ? ofs8 - 256 : ofs8;
    v = code + s;
    if (v > 16383) v = 16383;
    if (v < 0) v = 0;
    if (inv) v = 16383 - v;
    if (twos) v = (v >= 8192) ? v - 8192 : v + 8192;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=0x%04h exp=0x%04h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit stb, int code, int ofs8, bit inv, bit twos);
    @(negedge clk);
    smp_stb = stb; smp_code = code[13:0]; trim_ofs = ofs8[7:0];
    inv_en = inv; twos_en = twos;
    if (stb) exp_word = model(code, ofs8, inv, twos);
    @(negedge clk);
    smp_stb = 1'b0;
    check({tag, " R2 vld"}, int'(fmt_vld), int'(stb));
    check(tag, int'(fmt_code), exp_word);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check("R1 reset code", int'(fmt_code), 0);
    check("R1 reset vld", int'(fmt_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post code", int'(fmt_code), 0);
    check("R1 post vld", int'(fmt_vld), 0);

    step("R3 plus5", 1, 100, 5, 0, 0);
    step("R3 minus128", 1, 1000, 8'h80, 0, 0);
    step("R3 plus127", 1, 5000, 8'h7F, 0, 0);
    step("R4 top", 1, 16368, 127, 0, 0);
    step("R4 exact", 1, 16256, 127, 0, 0);
    step("R5 bottom", 1, 3, 8'hF6, 0, 0);
    step("R5 exact", 1, 128, 8'h80, 0, 0);
    step("R6 invert", 1, 256, 0, 1, 0);
    step("R6 inv clamp", 1, 16380, 100, 1, 0);
    step("R7 mid", 1, 8192, 0, 0, 1);
    step("R7 zero", 1, 0, 0, 0, 1);
    step("R9 both", 1, 0, 0, 1, 1);
    step("R9 both clamp", 1, 16383, 50, 1, 1);
    step("R8 hold1", 0, 777, 33, 1, 1);
    step("R8 hold2", 0, 12, 8'h80, 0, 0);
    step("R2 resume", 1, 4321, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      int code;
      int sel;
      sel = $urandom_range(3);
      if (sel == 0) code = $urandom_range(16383, 16200);
      else if (sel == 1) code = $urandom_range(180);
      else code = $urandom_range(16383);
      step("R3 R4 R5 R6 R7 R8 rnd", ($urandom_range(3) != 0), code,
           $urandom_range(255), $urandom_range(1), $urandom_range(1));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule